// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is a memory-mapped 32-bit down-counter for periodic or single-shot event generation. Software first sets a divide code, then a control word holding an 8-bit vector, a mask bit and a reload-mode bit. Writing a start value to the load register copies it into the counter and begins the count. The counter steps down by one on every prescaled tick. The prescaler yields one tick every N input clocks, where N is a power of two from 1 to 128. Software can read the remaining count at any time. The elapsed number of ticks is the load value minus the remaining count.

When the count steps from one to zero, the block issues a single-cycle interrupt request carrying the vector, unless the mask bit is set. In single-shot mode the counter then rests at zero. In reload mode the counter takes the load value again on that same tick, so the request repeats every load-value ticks. Loading zero halts the timer. A changed divide code is picked up only when the prescaler next wraps, so a tick already in progress always completes at the old rate.

Top module: `cdtimer`

## Requirements
- R1: After reset, the current count, control word, load value and divide code all read 0, and `irqValid` is low.
- R2: The control word sits at 0x320, with the vector in bits 7:0, the mask in bit 16 and the reload mode in bit 17. The load value is at 0x380, the current count at 0x390 and the divide code (4 bits) at 0x3e0. Unused control bits read 0, and any other address reads 0.
- R3: A write to 0x380 puts the written value in the counter on that clock edge and restarts the prescaler from zero. The count then falls by exactly one per tick.
- R4: The divide codes are 0xb for 1, 0x0 for 2, 0x1 for 4, 0x2 for 8, 0x3 for 16, 0x8 for 32, 0x9 for 64 and 0xa for 128. Bit 2 of the code is ignored, so 0xf means 1 and 0x4 means 2. After a load of V at edge E0, the first decrement lands on edge E(N).
- R5: In single-shot mode, the edge that takes the count from 1 to 0 raises `irqValid` for exactly one cycle, with `irqVector` equal to bits 7:0 of the control word. The count then stays at 0.
- R6: In reload mode, the edge that would reach zero instead loads the count from the load value and raises `irqValid` for one cycle. This repeats every V*N clocks.
- R7: When bit 16 is set, no request is raised, but the count and its reloads carry on unchanged.
- R8: Loading zero, whether idle or mid-count, leaves the count at 0 and raises no request.
- R9: A divide code written while counting takes effect only after the prescaler next wraps at the old rate.
- R10: A load value of 0xFFFFFFFF is accepted, and after k ticks the count reads 0xFFFFFFFF minus k.
- R11: Writes to the current-count address 0x390 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector accompanying the request |

## Verification
The bench builds the block with its default 32-bit counter and 12-bit address. This makes the full-width load value of R10 and the register offsets of R2 directly reachable. The vector table runs every divide code, including the two codes whose bit 2 must be ignored. For each code it samples the exact edge of the first decrement and the exact edge of the zero crossing. Directed sequences cover reload, masking, zero loads, a restart that must clear the prescaler, and a divide change that must wait for the old wrap.

// File: rtl/cdtimer_pkg.sv
`timescale 1ns/1ps
package cdtimer_pkg;

  // Register byte offsets decoded by software
  localparam logic [11:0] OFS_MODE = 12'h320;
  localparam logic [11:0] OFS_LOAD = 12'h380;
  localparam logic [11:0] OFS_CUR  = 12'h390;
  localparam logic [11:0] OFS_DIV  = 12'h3e0;

  // Control word field positions
  localparam int VEC_W      = 8;
  localparam int MASK_BIT   = 16;
  localparam int RELOAD_BIT = 17;

  // Prescaler sizing: largest divide is 2**MAX_SHIFT
  localparam int MAX_SHIFT = 7;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int PRE_W     = MAX_SHIFT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic tick;
    logic reload;
  } dpStrobe_t;

  // Map code bits {3,1,0} to a shift amount; 3'b111 means divide by 1
  function automatic logic [SHIFT_W-1:0] divShift(input logic [2:0] codeBits);
    if (codeBits == 3'b111) return '0;
    else return SHIFT_W'(codeBits) + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/cdtimer_dp.sv
`timescale 1ns/1ps
module cdtimer_dp
  import cdtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] count,
  output logic             hitZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic lastStep;
  assign lastStep = (count == ONE);
  assign hitZero  = strobe.tick && lastStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= loadVal;
    end else if (strobe.tick) begin
      if (lastStep && strobe.reload) count <= initVal;
      else                           count <= count - ONE;
    end
  end

  // R3: a load puts the written value in the counter
  p_load_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> count == $past(loadVal));

  // R3: a tick above one steps down by exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.load && count > ONE) |=> count == $past(count) - ONE);

  // R6: reload mode refills instead of resting at zero
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hitZero && strobe.reload) |=> count == $past(initVal));

  // R8: an idle counter stays at zero until the next load
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !strobe.load) |=> count == '0);

endmodule

// File: rtl/cdtimer_ctrl.sv
`timescale 1ns/1ps
module cdtimer_ctrl
  import cdtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [CNT_W-1:0]  curCount,
  input  logic              hitZero,
  output dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  initVal,
  output logic [31:0]       rdData,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);

  // Register decode
  logic selMode, selLoad, selCur, selDiv;
  assign selMode = (addr == ADDR_W'(OFS_MODE));
  assign selLoad = (addr == ADDR_W'(OFS_LOAD));
  assign selCur  = (addr == ADDR_W'(OFS_CUR));
  assign selDiv  = (addr == ADDR_W'(OFS_DIV));

  logic wrMode, wrLoad, wrDiv;
  assign wrMode = wrEn && selMode;
  assign wrLoad = wrEn && selLoad;
  assign wrDiv  = wrEn && selDiv;

  // Programmable state
  logic [VEC_W-1:0] vecReg;
  logic             maskBit;
  logic             reloadBit;
  logic [3:0]       divCode;
  logic [CNT_W-1:0] initReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg    <= '0;
      maskBit   <= 1'b0;
      reloadBit <= 1'b0;
      divCode   <= '0;
      initReg   <= '0;
    end else begin
      if (wrMode) begin
        vecReg    <= wrData[VEC_W-1:0];
        maskBit   <= wrData[MASK_BIT];
        reloadBit <= wrData[RELOAD_BIT];
      end
      if (wrDiv)  divCode <= wrData[3:0];
      if (wrLoad) initReg <= wrData[CNT_W-1:0];
    end
  end

  // Prescaler: the shift in use is refreshed only on a wrap or while idle
  logic [PRE_W-1:0]   preCnt;
  logic [SHIFT_W-1:0] activeShift;
  logic [PRE_W-1:0]   preLim;
  logic               running;
  logic               rollover;
  logic [SHIFT_W-1:0] nextShift;

  assign running   = (curCount != '0);
  assign preLim    = ~({PRE_W{1'b1}} << activeShift);
  assign rollover  = (preCnt == preLim);
  assign nextShift = divShift({divCode[3], divCode[1:0]});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt      <= '0;
      activeShift <= '0;
    end else if (wrLoad || !running || rollover) begin
      preCnt      <= '0;
      activeShift <= nextShift;
    end else begin
      preCnt      <= preCnt + PRE_W'(1);
    end
  end

  // Strobes to the datapath
  always_comb begin
    strobe        = '0;
    strobe.load   = wrLoad;
    strobe.tick   = running && rollover && !wrLoad;
    strobe.reload = reloadBit;
  end
  assign loadVal = wrData[CNT_W-1:0];
  assign initVal = initReg;

  // Interrupt request register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid  <= hitZero && !maskBit;
      irqVector <= vecReg;
    end
  end

  // Read mux
  always_comb begin
    rdData = '0;
    if (selMode) begin
      rdData[VEC_W-1:0]  = vecReg;
      rdData[MASK_BIT]   = maskBit;
      rdData[RELOAD_BIT] = reloadBit;
    end else if (selLoad) begin
      rdData = 32'(initReg);
    end else if (selCur) begin
      rdData = 32'(curCount);
    end else if (selDiv) begin
      rdData = {28'd0, divCode};
    end
  end

  // R4: the prescaler never passes the limit of the shift in use
  p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLim);

  // R9: the shift in use holds between wraps while counting
  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && !rollover && !wrLoad) |=> $stable(activeShift));

  // R7: a masked timer raises no request
  p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(maskBit));

  // R5: a single-shot request lasts one cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !$past(reloadBit)) |=> !irqValid);

endmodule

// File: rtl/cdtimer.sv
`timescale 1ns/1ps
module cdtimer
  import cdtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irqValid,
  output logic [7:0]        irqVector
);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] count;
  logic             hitZero;

  cdtimer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .curCount  (count),
    .hitZero   (hitZero),
    .strobe    (strobe),
    .loadVal   (loadVal),
    .initVal   (initVal),
    .rdData    (rdData),
    .irqValid  (irqValid),
    .irqVector (irqVector)
  );

  cdtimer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (loadVal),
    .initVal (initVal),
    .count   (count),
    .hitZero (hitZero)
  );

  // R11: with no load, the count never rises except through a reload
  p_no_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !hitZero) |=> count <= $past(count));

endmodule

// File: tb/cdtimer_bench.sv
`timescale 1ns/1ps
module cdtimer_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_MODE = 12'h320;
  localparam logic [11:0] A_LOAD = 12'h380;
  localparam logic [11:0] A_CUR  = 12'h390;
  localparam logic [11:0] A_DIV  = 12'h3e0;

  // {divide code, divide ratio, load value, vector}
  localparam logic [27:0] TBL [0:9] = '{
    {4'hb, 8'd1,   8'd5, 8'h20},
    {4'h0, 8'd2,   8'd4, 8'h21},
    {4'h1, 8'd4,   8'd3, 8'h22},
    {4'h2, 8'd8,   8'd3, 8'h23},
    {4'h3, 8'd16,  8'd2, 8'h24},
    {4'h8, 8'd32,  8'd2, 8'h25},
    {4'h9, 8'd64,  8'd2, 8'h26},
    {4'ha, 8'd128, 8'd2, 8'h27},
    {4'hf, 8'd1,   8'd6, 8'h28},
    {4'h4, 8'd2,   8'd3, 8'h29}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = A_CUR;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqValid;
  logic [7:0]  irqVector;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdtimer u_cdtimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqValid(irqValid), .irqVector(irqVector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0; addr = A_CUR; wrData = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
    addr = A_CUR;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seen;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 irq", {31'd0, irqValid}, 32'd0);
    rd(A_CUR, v);  chk("R1 cur", v, 32'd0);
    rd(A_MODE, v); chk("R1 mode", v, 32'd0);
    rd(A_LOAD, v); chk("R1 load", v, 32'd0);
    rd(A_DIV, v);  chk("R1 div", v, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R2: field layout and unmapped reads
    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, v); chk("R2 mode fields", v, 32'h0003_00FF);
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, v);  chk("R2 div width", v, 32'h0000_000F);
    rd(12'h100, v); chk("R2 unmapped", v, 32'd0);
    wr(A_LOAD, 32'h0);
    rd(A_LOAD, v); chk("R2 load readback", v, 32'd0);

    // R4/R5: table of divide codes in single-shot mode
    for (int i = 0; i < 10; i++) begin
      logic [3:0] code;
      int n, ld;
      logic [7:0] vec;
      code = TBL[i][27:24];
      n    = int'(TBL[i][23:16]);
      ld   = int'(TBL[i][15:8]);
      vec  = TBL[i][7:0];
      wr(A_DIV, {28'd0, code});
      wr(A_MODE, {24'd0, vec});
      wr(A_LOAD, ld);
      edges(n - 1);
      chk($sformatf("R4 code %0h before first tick", code), rdData, ld);
      edges(1);
      chk($sformatf("R4 code %0h first tick", code), rdData, ld - 1);
      edges(ld * n - n - 1);
      chk($sformatf("R5 code %0h count one", code), rdData, 32'd1);
      chk($sformatf("R5 code %0h no early irq", code), {31'd0, irqValid}, 32'd0);
      edges(1);
      chk($sformatf("R5 code %0h irq", code), {31'd0, irqValid}, 32'd1);
      chk($sformatf("R5 code %0h vector", code), {24'd0, irqVector}, {24'd0, vec});
      chk($sformatf("R5 code %0h zero", code), rdData, 32'd0);
      edges(1);
      chk($sformatf("R5 code %0h pulse ends", code), {31'd0, irqValid}, 32'd0);
      chk($sformatf("R5 code %0h rests", code), rdData, 32'd0);
    end

    // R6: reload mode, divide by 1, load 5
    wr(A_DIV, 32'hb);
    wr(A_MODE, 32'h0002_0041);
    wr(A_LOAD, 32'd5);
    edges(4);
    chk("R6 count one", rdData, 32'd1);
    edges(1);
    chk("R6 irq first", {31'd0, irqValid}, 32'd1);
    chk("R6 vector", {24'd0, irqVector}, 32'h41);
    chk("R6 reloaded", rdData, 32'd5);
    edges(1);
    chk("R6 pulse ends", {31'd0, irqValid}, 32'd0);
    chk("R6 continues", rdData, 32'd4);
    edges(4);
    chk("R6 irq second", {31'd0, irqValid}, 32'd1);
    chk("R6 reloaded again", rdData, 32'd5);
    wr(A_LOAD, 32'd0);

    // R7: masked reload mode keeps counting silently
    wr(A_MODE, 32'h0003_0042);
    wr(A_LOAD, 32'd3);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      edges(1);
      if (irqValid) seen++;
    end
    chk("R7 no irq while masked", seen, 0);
    chk("R7 count continues", rdData, 32'd2);
    wr(A_LOAD, 32'd0);

    // R8: zero load halts without a request
    wr(A_MODE, 32'h0000_0043);
    wr(A_LOAD, 32'd0);
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      edges(1);
      if (irqValid) seen++;
    end
    chk("R8 idle no irq", seen, 0);
    chk("R8 idle count", rdData, 32'd0);
    wr(A_LOAD, 32'd5);
    wr(A_LOAD, 32'd0);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      edges(1);
      if (irqValid) seen++;
    end
    chk("R8 stopped no irq", seen, 0);
    chk("R8 stopped count", rdData, 32'd0);

    // R3: reload mid-tick restarts the prescaler (divide by 4)
    wr(A_DIV, 32'h1);
    wr(A_LOAD, 32'd10);
    edges(1);
    wr(A_LOAD, 32'd20);
    chk("R3 new value", rdData, 32'd20);
    edges(3);
    chk("R3 held full period", rdData, 32'd20);
    edges(1);
    chk("R3 first step", rdData, 32'd19);
    wr(A_LOAD, 32'd0);

    // R9: divide change waits for the old wrap (4 -> 2)
    wr(A_MODE, 32'h0000_0044);
    wr(A_DIV, 32'h1);
    wr(A_LOAD, 32'd10);
    edges(1);
    wr(A_DIV, 32'h0);
    edges(2);
    chk("R9 old rate tick", rdData, 32'd9);
    edges(4);
    chk("R9 new rate", rdData, 32'd7);
    wr(A_LOAD, 32'd0);

    // R10: all-ones load value
    wr(A_DIV, 32'hb);
    wr(A_LOAD, 32'hFFFF_FFFF);
    chk("R10 loaded", rdData, 32'hFFFF_FFFF);
    edges(3);
    chk("R10 count", rdData, 32'hFFFF_FFFC);
    chk("R10 elapsed", 32'hFFFF_FFFF - rdData, 32'd3);
    wr(A_LOAD, 32'd0);

    // R11: writes to the current count are ignored
    wr(A_LOAD, 32'd100);
    wr(A_CUR, 32'd123);
    #1;
    chk("R11 write ignored", rdData, 32'd99);
    edges(1);
    chk("R11 keeps counting", rdData, 32'd98);
    wr(A_LOAD, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule